// File: doc/BRIEF.md
# ASCII command to AXI-Lite master

This block turns a stream of human-readable text bytes into AXI-Lite bus transactions. Bytes arrive one at a time over a valid/ready pair from a serial receiver. A line such as `W 00000010 DEADBEEF` followed by a line feed becomes one single-beat write, and `R 00000010` becomes one read. Each completed command, and each malformed one, produces a single response request for a separate serializer: OK, ERR, or read data together with its address.

Everything is sequential. While a bus transaction is in flight, while a response request waits to be taken, and while the serializer reports that it is still sending, the byte input is held off. A host can therefore stream several commands without pacing, and each command still completes its bus transfer and its reply before the next byte is read. The write path puts the address and the data out one after the other, so slaves that cannot take both at once still work.

Top module: `asc_axil_master`

## Requirements
- R1: A command starts with `W`/`w` (write) or `R`/`r` (read). Any other byte in the idle state, apart from skipped whitespace, produces an error response (kind 2) and no bus transaction.
- R2: The address and the data fields each take exactly 8 hex digits in any mix of upper and lower case, with the first digit the most significant. A field that ends before its 8th digit produces an error response.
- R3: Space (0x20) and tab (0x09) are skipped before the first digit of a field. Any other non-hex byte inside a field, including whitespace after its first digit, produces an error response.
- R4: After the 8th address digit, a read expects the end of the line at once and a write expects the data field.
- R5: At the end of a line, carriage return (0x0D) is ignored and line feed (0x0A) commits the command. Any other byte produces an error response and no bus transaction.
- R6: `in_ready` is high only when the bus side is idle, `rsp_valid` is low and `rsp_busy` is low. Commands sent back to back are all executed in order, with no byte lost.
- R7: A write presents AWVALID, then WVALID after the AW handshake, then BREADY after the W handshake. AWVALID and WVALID are never high together. `m_awaddr`/`m_wdata` carry the parsed fields, WSTRB is all ones and both PROT outputs are zero.
- R8: A read presents ARVALID, then RREADY after the AR handshake. The R handshake produces a response of kind 3 with `rsp_addr` equal to the parsed address and `rsp_data` equal to the RDATA that was captured.
- R9: The B handshake produces a response of kind 1. A response request holds `rsp_valid`, `rsp_kind` and `rsp_data` steady until `rsp_ready`. BRESP and RRESP do not affect the outcome.
- R10: After an error the parser is idle again. In the idle state space, tab, CR and LF are skipped, and the next command is executed normally.
- R11: An asynchronous active-low reset returns both state machines to idle with every VALID/READY output low, `rsp_valid` low, and `in_ready` high while `rsp_busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_data | input | 8 | Received byte |
| in_valid | input | 1 | Byte available |
| in_ready | output | 1 | Byte accepted this cycle when valid |
| m_awaddr | output | ADDR_W | Write address |
| m_awprot | output | 3 | Write protection, zero |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_wdata | output | DATA_W | Write data |
| m_wstrb | output | DATA_W/8 | Write strobes, all ones |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_bresp | input | 2 | Write response code, ignored |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| m_araddr | output | ADDR_W | Read address |
| m_arprot | output | 3 | Read protection, zero |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_rdata | input | DATA_W | Read data |
| m_rresp | input | 2 | Read response code, ignored |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready |
| rsp_valid | output | 1 | Response request pending |
| rsp_ready | input | 1 | Serializer takes the request |
| rsp_kind | output | 2 | 1 = OK, 2 = ERR, 3 = read data |
| rsp_addr | output | ADDR_W | Address of the command |
| rsp_data | output | DATA_W | Captured read data |
| rsp_busy | input | 1 | Serializer still sending the previous reply |

## Verification
The hardest case to reach is a byte that is already waiting while the block is stalled. For that, a write and a read must be streamed as one uninterrupted string. The driver keeps `in_valid` high throughout, while the slave stretches its handshakes and the serializer model holds `rsp_busy` for several cycles. The read then has to return the value the preceding write stored, which shows that no byte was taken early. Error recovery is the second difficult area. Strings are chosen so that one malformed line breaks up into a known number of error responses: bytes after the error are parsed again from the idle state. The scoreboard also counts address handshakes, so every ERR proves that no bus transaction was issued.

// File: rtl/asc_axil_master.sv
module asc_axil_master #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [ADDR_W-1:0] m_awaddr,
  output logic [2:0]        m_awprot,
  output logic              m_awvalid,
  input  logic              m_awready,
  output logic [DATA_W-1:0] m_wdata,
  output logic [DATA_W/8-1:0] m_wstrb,
  output logic              m_wvalid,
  input  logic              m_wready,
  input  logic [1:0]        m_bresp,
  input  logic              m_bvalid,
  output logic              m_bready,
  output logic [ADDR_W-1:0] m_araddr,
  output logic [2:0]        m_arprot,
  output logic              m_arvalid,
  input  logic              m_arready,
  input  logic [DATA_W-1:0] m_rdata,
  input  logic [1:0]        m_rresp,
  input  logic              m_rvalid,
  output logic              m_rready,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [1:0]        rsp_kind,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [DATA_W-1:0] rsp_data,
  input  logic              rsp_busy
);
  localparam int NA   = ADDR_W / 4;
  localparam int ND   = DATA_W / 4;
  localparam int NMAX = (NA > ND) ? NA : ND;
  localparam int CW   = $clog2(NMAX) + 1;
  localparam logic [1:0] K_OK = 2'd1, K_ERR = 2'd2, K_RD = 2'd3;

  typedef enum logic [1:0] {P_IDLE, P_ADDR, P_DATA, P_EOL} pst_t;
  typedef enum logic [2:0] {B_IDLE, B_AW, B_W, B_B, B_AR, B_R} bst_t;

  function automatic logic is_hex(input logic [7:0] c);
    return (c >= 8'h30 && c <= 8'h39) || (c >= 8'h41 && c <= 8'h46) ||
           (c >= 8'h61 && c <= 8'h66);
  endfunction

  function automatic logic [3:0] hex_nib(input logic [7:0] c);
    return (c <= 8'h39) ? c[3:0] : c[3:0] + 4'd9;
  endfunction

  pst_t pst;
  bst_t bst;
  logic is_wr;
  logic [CW-1:0] cnt;
  logic [ADDR_W-1:0] acc_a;
  logic [DATA_W-1:0] acc_d;
  logic [DATA_W-1:0] rd_q;

  logic take, ws, eol_ch, hx, is_w, is_r, field, last_nib, perr, commit;
  logic unused_resp;

  assign take     = in_valid & in_ready;
  assign ws       = (in_data == 8'h20) || (in_data == 8'h09);
  assign eol_ch   = (in_data == 8'h0D) || (in_data == 8'h0A);
  assign hx       = is_hex(in_data);
  assign is_w     = (in_data == 8'h57) || (in_data == 8'h77);
  assign is_r     = (in_data == 8'h52) || (in_data == 8'h72);
  assign field    = (pst == P_ADDR) || (pst == P_DATA);
  assign last_nib = (pst == P_ADDR) ? (cnt == CW'(NA - 1)) : (cnt == CW'(ND - 1));
  assign perr     = take && (((pst == P_IDLE) && !is_w && !is_r && !ws && !eol_ch) ||
                             (field && !hx && !(ws && cnt == '0)) ||
                             ((pst == P_EOL) && !eol_ch));
  assign commit   = take && (pst == P_EOL) && (in_data == 8'h0A);

  assign in_ready    = (bst == B_IDLE) && !rsp_valid && !rsp_busy;
  assign unused_resp = ^{m_bresp, m_rresp};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pst   <= P_IDLE;
      is_wr <= 1'b0;
      cnt   <= '0;
      acc_a <= '0;
      acc_d <= '0;
    end else if (perr) begin
      pst <= P_IDLE;
    end else if (take) begin
      case (pst)
        P_IDLE:
          if (is_w || is_r) begin
            is_wr <= is_w;
            cnt   <= '0;
            acc_a <= '0;
            acc_d <= '0;
            pst   <= P_ADDR;
          end
        P_ADDR, P_DATA:
          if (hx) begin
            if (pst == P_ADDR) acc_a <= {acc_a[ADDR_W-5:0], hex_nib(in_data)};
            else               acc_d <= {acc_d[DATA_W-5:0], hex_nib(in_data)};
            if (last_nib) begin
              cnt <= '0;
              pst <= (pst == P_ADDR && is_wr) ? P_DATA : P_EOL;
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
        P_EOL:
          if (commit) pst <= P_IDLE;
        default: pst <= P_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bst       <= B_IDLE;
      rsp_valid <= 1'b0;
      rsp_kind  <= K_OK;
      rd_q      <= '0;
    end else begin
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
      if (perr) begin
        rsp_valid <= 1'b1;
        rsp_kind  <= K_ERR;
      end
      case (bst)
        B_IDLE: if (commit) bst <= is_wr ? B_AW : B_AR;
        B_AW:   if (m_awready) bst <= B_W;
        B_W:    if (m_wready) bst <= B_B;
        B_B:
          if (m_bvalid) begin
            bst       <= B_IDLE;
            rsp_valid <= 1'b1;
            rsp_kind  <= K_OK;
          end
        B_AR:   if (m_arready) bst <= B_R;
        B_R:
          if (m_rvalid) begin
            bst       <= B_IDLE;
            rd_q      <= m_rdata;
            rsp_valid <= 1'b1;
            rsp_kind  <= K_RD;
          end
        default: bst <= B_IDLE;
      endcase
    end
  end

  assign m_awaddr  = acc_a;
  assign m_araddr  = acc_a;
  assign m_wdata   = acc_d;
  assign m_wstrb   = '1;
  assign m_awprot  = 3'b000;
  assign m_arprot  = 3'b000;
  assign m_awvalid = (bst == B_AW);
  assign m_wvalid  = (bst == B_W);
  assign m_bready  = (bst == B_B);
  assign m_arvalid = (bst == B_AR);
  assign m_rready  = (bst == B_R);
  assign rsp_addr  = acc_a;
  assign rsp_data  = rd_q;
endmodule

module asc_axil_master_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic [ADDR_W-1:0] m_awaddr,
  input logic [2:0]        m_awprot,
  input logic              m_awvalid,
  input logic              m_awready,
  input logic [DATA_W/8-1:0] m_wstrb,
  input logic              m_wvalid,
  input logic              m_bvalid,
  input logic              m_bready,
  input logic [ADDR_W-1:0] m_araddr,
  input logic [2:0]        m_arprot,
  input logic              m_arvalid,
  input logic              m_arready,
  input logic [DATA_W-1:0] m_rdata,
  input logic              m_rvalid,
  input logic              m_rready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [1:0]        rsp_kind,
  input logic [DATA_W-1:0] rsp_data,
  input logic              rsp_busy
);
  AST_AW_W_APART: assert property (@(posedge clk) disable iff (!rst_n)
    !(m_awvalid && m_wvalid)); // R7
  AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({m_awvalid, m_wvalid, m_bready, m_arvalid, m_rready})); // R7
  AST_W_AFTER_AW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_wvalid) |-> $past(m_awvalid && m_awready)); // R7
  AST_AW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    m_awvalid && !m_awready |=> m_awvalid && $stable(m_awaddr)); // R7
  AST_STRB_PROT: assert property (@(posedge clk) disable iff (!rst_n)
    (m_wvalid |-> &m_wstrb) and (m_awprot == 3'b000) and (m_arprot == 3'b000)); // R7
  AST_AR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    m_arvalid && !m_arready |=> m_arvalid && $stable(m_araddr)); // R8
  AST_RD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) && rsp_kind == 2'd3 |-> $past(m_rvalid && m_rready) && rsp_data == $past(m_rdata)); // R8
  AST_OK_AFTER_B: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) && rsp_kind == 2'd1 |-> $past(m_bvalid && m_bready)); // R9
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_kind) && $stable(rsp_data)); // R9
  AST_IN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !rsp_valid && !rsp_busy && !m_awvalid && !m_wvalid && !m_bready && !m_arvalid && !m_rready); // R6
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_kind == 2'd2 |-> !m_awvalid && !m_arvalid); // R1
endmodule

bind asc_axil_master asc_axil_master_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready),
  .m_awaddr(m_awaddr), .m_awprot(m_awprot), .m_awvalid(m_awvalid), .m_awready(m_awready),
  .m_wstrb(m_wstrb), .m_wvalid(m_wvalid), .m_bvalid(m_bvalid), .m_bready(m_bready),
  .m_araddr(m_araddr), .m_arprot(m_arprot), .m_arvalid(m_arvalid), .m_arready(m_arready),
  .m_rdata(m_rdata), .m_rvalid(m_rvalid), .m_rready(m_rready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_kind(rsp_kind),
  .rsp_data(rsp_data), .rsp_busy(rsp_busy)
);

// File: tb/tb_asc_axil_master.sv
`timescale 1ns/1ps
module tb_asc_axil_master;
  localparam logic [1:0] OK = 2'd1, ERR = 2'd2, RD = 2'd3;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [7:0] in_data;
  logic in_valid, in_ready;
  logic [31:0] m_awaddr, m_wdata, m_araddr, m_rdata, rsp_addr, rsp_data;
  logic [2:0] m_awprot, m_arprot;
  logic [3:0] m_wstrb;
  logic m_awvalid, m_awready, m_wvalid, m_wready, m_bvalid, m_bready;
  logic m_arvalid, m_arready, m_rvalid, m_rready;
  logic [1:0] m_bresp, m_rresp, rsp_kind;
  logic rsp_valid, rsp_ready, rsp_busy;

  asc_axil_master dut (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .m_awaddr(m_awaddr), .m_awprot(m_awprot), .m_awvalid(m_awvalid), .m_awready(m_awready),
    .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wvalid(m_wvalid), .m_wready(m_wready),
    .m_bresp(m_bresp), .m_bvalid(m_bvalid), .m_bready(m_bready),
    .m_araddr(m_araddr), .m_arprot(m_arprot), .m_arvalid(m_arvalid), .m_arready(m_arready),
    .m_rdata(m_rdata), .m_rresp(m_rresp), .m_rvalid(m_rvalid), .m_rready(m_rready),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_kind(rsp_kind),
    .rsp_addr(rsp_addr), .rsp_data(rsp_data), .rsp_busy(rsp_busy)
  );

  int n_chk = 0, n_fail = 0;
  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic [1:0]  kind;
    logic [31:0] addr;
    logic [31:0] data;
    logic [31:0] hs;
    logic [31:0] tag;
  } exp_t;
  exp_t q[$];
  int exp_hs = 0;
  int hs_cnt = 0;
  int viol_gate = 0, viol_overlap = 0, viol_order = 0, viol_strb = 0;

  task automatic push(input logic [1:0] k, input logic [31:0] a, input logic [31:0] d, input int req);
    if (k != ERR) exp_hs++;
    q.push_back('{k, a, d, exp_hs, req});
  endtask

  // Memory-model slave with stretched handshakes; BRESP/RRESP are non-zero on purpose (R9)
  logic [31:0] mem [16];
  logic [31:0] aw_q;
  logic aw_seen;
  logic [3:0] tick;
  assign m_bresp = 2'b10;
  assign m_rresp = 2'b10;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick <= '0; m_awready <= 0; m_wready <= 0; m_bvalid <= 0;
      m_arready <= 0; m_rvalid <= 0; m_rdata <= '0; aw_q <= '0; aw_seen <= 0;
      for (int i = 0; i < 16; i++) mem[i] <= '0;
    end else begin
      tick <= tick + 1'b1;
      m_awready <= m_awvalid && !m_awready && tick[0];
      m_wready  <= m_wvalid && !m_wready && tick[1];
      m_arready <= m_arvalid && !m_arready && tick[0];
      if (m_awvalid && m_awready) begin
        aw_q <= m_awaddr; aw_seen <= 1'b1; hs_cnt++;
      end
      if (m_wvalid && m_wready) begin
        if (!aw_seen) viol_order++;
        if (m_wstrb != 4'hF || m_awprot != 3'd0) viol_strb++;
        mem[aw_q[5:2]] <= m_wdata;
        aw_seen <= 1'b0;
        m_bvalid <= 1'b1;
      end
      if (m_bvalid && m_bready) m_bvalid <= 1'b0;
      if (m_arvalid && m_arready) begin
        if (m_arprot != 3'd0) viol_strb++;
        m_rdata <= mem[m_araddr[5:2]]; m_rvalid <= 1'b1; hs_cnt++;
      end
      if (m_rvalid && m_rready) m_rvalid <= 1'b0;
    end
  end

  // Gate and channel watcher (R6, R7)
  always begin
    @(negedge clk); #1;
    if (rst_n) begin
      if (in_ready && (rsp_valid || rsp_busy || m_awvalid || m_wvalid || m_bready || m_arvalid || m_rready))
        viol_gate++;
      if (m_awvalid && m_wvalid) viol_overlap++;
    end
  end

  // Scoreboard monitor and serializer model
  initial begin
    exp_t e;
    rsp_ready = 0; rsp_busy = 0;
    forever begin
      @(negedge clk);
      if (rst_n && rsp_valid) begin
        if (q.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL R9 unexpected response: actual kind %0d expected none", rsp_kind);
        end else begin
          e = q.pop_front();
          chk($sformatf("R%0d", e.tag), "kind", {30'd0, rsp_kind}, {30'd0, e.kind});
          chk($sformatf("R%0d", e.tag), "bus handshakes", hs_cnt, e.hs);
          if (e.kind == RD) begin
            chk($sformatf("R%0d", e.tag), "rsp_addr", rsp_addr, e.addr);
            chk($sformatf("R%0d", e.tag), "rsp_data", rsp_data, e.data);
          end
        end
        repeat (2) @(negedge clk);
        rsp_ready = 1;
        @(negedge clk);
        rsp_ready = 0; rsp_busy = 1;
        repeat (6) @(negedge clk);
        rsp_busy = 0;
      end
    end
  end

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1; in_data = b;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk);
  endtask

  task automatic send(input string s);
    for (int i = 0; i < s.len(); i++) send_byte(s[i]);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    in_valid = 0; in_data = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", "in_ready in reset", in_ready, 1);
    chk("R11", "valids in reset", {m_awvalid, m_wvalid, m_bready, m_arvalid, m_rready, rsp_valid}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R11", "in_ready after reset", in_ready, 1);
    chk("R11", "valids after reset", {m_awvalid, m_wvalid, m_bready, m_arvalid, m_rready, rsp_valid}, 0);

    push(OK, 0, 0, 7);                    send("W 00000010 DEADBEEF\n");          // R7 R9
    push(RD, 32'h10, 32'hDEADBEEF, 8);    send("R 00000010\n");                   // R8
    push(OK, 0, 0, 2);                    send("w 0000001c cafef00d\r\n");        // R2 R5
    push(RD, 32'h1C, 32'hCAFEF00D, 3);    send("r\t0000001C\n");                  // R2 R3
    push(ERR, 0, 0, 1);                   send("X\n");                            // R1
    push(ERR, 0, 0, 3); push(ERR, 0, 0, 10); send("R 00 1\n");                    // R3 R10
    push(ERR, 0, 0, 4);                   send("R 000000100\n");                  // R4
    push(ERR, 0, 0, 4);                   send("W 00000004\n");                   // R4
    push(ERR, 0, 0, 5);                   send("W 00000004 1234abcd5\n");         // R5
    push(RD, 32'h4, 32'h0, 5);            send("R 00000004\n");                   // R5 write suppressed
    push(ERR, 0, 0, 2);                   send("W 00000008 0000000\n");           // R2
    push(RD, 32'h8, 32'h0, 2);            send("R 00000008\n");                   // R2 write suppressed
    push(OK, 0, 0, 6); push(RD, 32'h20, 32'h01234567, 6);
    send("W 00000020 01234567\nR 00000020\n");                                   // R6 back to back
    push(RD, 32'h3C, 32'h0, 10);          send(" \t\n\r\nR 0000003c\n");          // R10
    push(OK, 0, 0, 3);                    send("W \t0000003C  aBcDeF09\n");       // R3
    push(RD, 32'h3C, 32'hABCDEF09, 2);    send("R 0000003c\n");                   // R2

    while (q.size() != 0) @(negedge clk);
    repeat (20) @(negedge clk);
    chk("R6", "in_ready gate violations", viol_gate, 0);
    chk("R7", "AW/W overlap cycles", viol_overlap, 0);
    chk("R7", "W before AW handshake", viol_order, 0);
    chk("R7", "strobe or prot errors", viol_strb, 0);
    chk("R9", "responses left over", rsp_valid, 0);
    finish_run();
  end
endmodule